// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor port and a slower word-addressed main memory. It keeps 512 twelve-bit words as 64 lines of 8 words. Each line has one tag register and one valid flag. Every memory line can live in exactly one cache line, and that line is chosen by the middle address bits. Reads that find their line resident complete in the cycle they are presented. A read that misses loads the whole 8-word line from memory, replacing whatever the slot held, and then returns the requested word.

Stores always go to main memory. When the addressed line is resident, the cached copy is updated in the same cycle that memory accepts the store. A store to a line that is not resident leaves the cache untouched. The processor holds its request and operands stable until `cpu_ready` rises. The memory side uses a request/acknowledge handshake with any latency. Two counters, one for completed accesses and one for accesses that found their line resident, let the hit ratio be measured.

Top module: `dm_wt_cache`

## Requirements
- R1: A 15-bit address is split as tag = addr[14:9], line = addr[8:3], word = addr[2:0]. Data words are 12 bits. Two addresses with equal line and word fields but different tags never hit on each other's data.
- R2: After reset every line is invalid. The first read of any line therefore goes to memory. After reset `cpu_ready`, `mem_req` and both counters are 0.
- R3: A read whose line is resident and whose tag matches raises `cpu_ready` in the same cycle as the request, with the cached word on `cpu_rdata`, and issues no memory request.
- R4: A read miss issues exactly 8 memory reads to the addresses {tag, line, 0} through {tag, line, 7}, in ascending word order.
- R5: The requested word is returned with `cpu_ready` one cycle after the eighth read acknowledge. The line is then resident.
- R6: A fill replaces the line previously held in that slot, so that the old tag misses afterwards.
- R7: A store whose line is resident writes `cpu_addr`/`cpu_wdata` to memory and also updates the cached word. A later read hits and returns the stored value.
- R8: A store to a non-resident line writes memory only. The line held in that slot stays resident with its old data, and a later read of the stored address misses and returns the new memory value.
- R9: `cpu_ready` stays low while a memory transaction is outstanding. A store completes in the cycle of its memory acknowledge, and a read miss completes only after all 8 acknowledges.
- R10: `access_count` rises by one per completed access. `hit_count` rises by one per completed access whose line was resident when presented. Neither counter moves in any other cycle.
- R11: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 15 | Word address |
| cpu_wdata | input | 12 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 12 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 12 | Memory read data, valid with mem_ack |
| hit_count | output | 16 | Accesses that found their line resident |
| access_count | output | 16 | Completed accesses |

## Verification
A store hit writes the cached word in the same cycle as the memory acknowledge. The last word of a fill lands in the same cycle as the tag and valid update. Stores are aimed at lines the bench has just filled, and at slots holding a different tag, under memory latencies that rotate between 0, 1 and 2 extra cycles. Each store is judged by the memory model's logged address and data and by a later read, which must hit with the new value for a resident line and miss for a foreign one. The read's memory traffic and returned word show whether the cache and the tag store changed together.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int LINE_W = 6,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [TAG_W-1:0]  wr_tag
);
  localparam int NLINES = 1 << LINE_W;

  logic [NLINES-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_line == LINE_W'(g));

    // valid flag: cleared by reset, set by a completed fill
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g] <= 1'b1;
      end
    end

    // tag register: no reset, qualified by valid
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign rd_valid = valid_q[rd_line];
  assign rd_tag   = tag_q[rd_line];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/cache_perf.sv
module cache_perf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_evt,
  input  logic             hit_evt,
  output logic [CNT_W-1:0] acc_cnt,
  output logic [CNT_W-1:0] hit_cnt
);
  logic [CNT_W-1:0] acc_d, hit_d;

  always_comb begin
    acc_d = acc_cnt + CNT_W'(1);
    hit_d = hit_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
    end else if (acc_evt) begin
      acc_cnt <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt <= '0;
    end else if (hit_evt) begin
      hit_cnt <= hit_d;
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int LINE_W = 6,
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hit,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              data_we,
  output logic [LINE_W+WORD_W-1:0] data_widx,
  output logic [DATA_W-1:0] data_wdata,
  output logic              tag_we,
  output logic              acc_evt,
  output logic              hit_evt
);
  localparam int IDX_W = LINE_W + WORD_W;
  localparam int BLK_W = ADDR_W - WORD_W;
  localparam logic [WORD_W-1:0] LAST_WORD = '1;

  cache_state_e      state_q, state_d;
  logic [WORD_W-1:0] fill_q, fill_d;
  logic              fill_en;
  logic              fill_last;

  assign fill_last = (fill_q == LAST_WORD);

  // next-state logic
  always_comb begin
    state_d = state_q;
    fill_d  = fill_q;
    fill_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req && cpu_we) begin
          state_d = ST_WRITE;
        end else if (cpu_req && !hit) begin
          state_d = ST_FILL;
          fill_d  = '0;
          fill_en = 1'b1;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          fill_d  = fill_q + WORD_W'(1);
          fill_en = 1'b1;
          if (fill_last) begin
            state_d = ST_RESP;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          state_d = ST_IDLE;
        end
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (fill_en) begin
      fill_q <= fill_d;
    end
  end

  // memory port
  always_comb begin
    mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
    mem_we    = (state_q == ST_WRITE);
    mem_wdata = cpu_wdata;
    if (state_q == ST_FILL) begin
      mem_addr = {cpu_addr[ADDR_W-1:WORD_W], fill_q};
    end else begin
      mem_addr = cpu_addr;
    end
  end

  // cache array updates: fill words, or a store to a resident line
  logic [BLK_W-1:0] blk_unused;
  assign blk_unused = cpu_addr[ADDR_W-1:WORD_W];

  always_comb begin
    data_we    = 1'b0;
    data_widx  = cpu_addr[IDX_W-1:0];
    data_wdata = cpu_wdata;
    tag_we     = 1'b0;
    if (state_q == ST_FILL && mem_ack) begin
      data_we    = 1'b1;
      data_widx  = {cpu_addr[IDX_W-1:WORD_W], fill_q};
      data_wdata = mem_rdata;
      tag_we     = fill_last;
    end else if (state_q == ST_WRITE && mem_ack && hit) begin
      data_we = 1'b1;
    end
  end

  // processor handshake and events
  always_comb begin
    cpu_ready = 1'b0;
    hit_evt   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cpu_ready = cpu_req && !cpu_we && hit;
        hit_evt   = cpu_ready;
      end
      ST_WRITE: begin
        cpu_ready = mem_ack;
        hit_evt   = mem_ack && hit;
      end
      ST_RESP:  cpu_ready = 1'b1;
      default:  cpu_ready = 1'b0;
    endcase
    acc_evt = cpu_ready;
  end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int LINE_W = 6,
  parameter int WORD_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  access_count
);
  localparam int IDX_W = LINE_W + WORD_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // lookup
  logic [TAG_W-1:0]  req_tag, rd_tag;
  logic [LINE_W-1:0] req_line;
  logic              rd_valid, hit;

  assign req_tag  = cpu_addr[ADDR_W-1:IDX_W];
  assign req_line = cpu_addr[IDX_W-1:WORD_W];
  assign hit      = rd_valid && (rd_tag == req_tag);

  logic              data_we, tag_we, acc_evt, hit_evt;
  logic [IDX_W-1:0]  data_widx;
  logic [DATA_W-1:0] data_wdata;

  cache_tag_store #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_line  (req_line),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .wr_en    (tag_we),
    .wr_line  (req_line),
    .wr_tag   (req_tag)
  );

  cache_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (data_we),
    .wr_idx  (data_widx),
    .wr_data (data_wdata),
    .rd_idx  (cpu_addr[IDX_W-1:0]),
    .rd_data (cpu_rdata)
  );

  cache_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LINE_W (LINE_W), .WORD_W (WORD_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .hit        (hit),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .data_we    (data_we),
    .data_widx  (data_widx),
    .data_wdata (data_wdata),
    .tag_we     (tag_we),
    .acc_evt    (acc_evt),
    .hit_evt    (hit_evt)
  );

  cache_perf #(.CNT_W(CNT_W)) u_perf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .acc_evt (acc_evt),
    .hit_evt (hit_evt),
    .acc_cnt (access_count),
    .hit_cnt (hit_count)
  );
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int WORD_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  access_count
);
  localparam logic [WORD_W-1:0] LASTW = '1;

  // R3: a completed load presented alone never uses memory in that cycle
  p_rdhit_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_ready) |-> !mem_req);

  // R4: fill reads stay inside the requested line
  p_fill_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:WORD_W] == cpu_addr[ADDR_W-1:WORD_W]));

  // R5: when the requested word is the last of the line, it equals the last fill beat
  p_last_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we && cpu_addr[WORD_W-1:0] == LASTW &&
     $past(mem_req) && $past(mem_ack) && !$past(mem_we))
    |-> (cpu_rdata == $past(mem_rdata)));

  // R7: a memory write carries the processor address and data
  p_write_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == cpu_addr && mem_wdata == cpu_wdata));

  // R9: a store completes only together with the memory acknowledge
  p_store_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_ack && mem_req && mem_we));

  // R10: counters move only after a completed access
  p_cnt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |=> ($stable(hit_count) && $stable(access_count)));

  // R11: an unacknowledged memory request holds
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind dm_wt_cache dm_wt_cache_chk #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORD_W (WORD_W), .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .cpu_ready    (cpu_ready),
  .cpu_rdata    (cpu_rdata),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .mem_rdata    (mem_rdata),
  .hit_count    (hit_count),
  .access_count (access_count)
);

// File: tb/tb_dm_wt_cache.sv
module tb_dm_wt_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [14:0] cpu_addr;
  logic [11:0] cpu_wdata;
  logic        cpu_ready;
  logic [11:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata;
  logic        mem_ack;
  logic [11:0] mem_rdata;
  logic [15:0] hit_count, access_count;

  dm_wt_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .access_count(access_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_acc = 0;
  int exp_hit = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [11:0] wr_mem [int];
  function automatic logic [11:0] mem_val(input logic [14:0] a);
    if (wr_mem.exists(int'(a))) return wr_mem[int'(a)];
    return 12'((int'(a) * 37 + 11) & 12'hfff);
  endfunction

  int          lat_cnt = 0, lat_sel = 0;
  int          reads_n = 0, writes_n = 0, hold_err = 0;
  int          rd_log [8];
  logic [14:0] last_waddr, held_addr;
  logic [11:0] last_wdata;
  bit          waiting = 0;

  initial begin mem_ack = 1'b0; mem_rdata = '0; end

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      waiting = 0;
    end else if (mem_req) begin
      if (!waiting) begin
        waiting   = 1;
        held_addr = mem_addr;
      end else if (mem_addr != held_addr) begin
        hold_err++;
      end
      if (lat_cnt == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_mem[int'(mem_addr)] = mem_wdata;
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
          writes_n++;
        end else begin
          mem_rdata = mem_val(mem_addr);
          if (reads_n < 8) rd_log[reads_n] = int'(mem_addr);
          reads_n++;
        end
        lat_sel = (lat_sel + 1) % 3;
        lat_cnt = lat_sel;
      end else begin
        lat_cnt--;
      end
    end
  end

  // ---------------- processor access ----------------
  task automatic access(input bit we, input logic [5:0] tg, input logic [5:0] ln,
                        input logic [2:0] wd, input logic [11:0] wdat,
                        input bit exp_is_hit, input logic [11:0] exp_rd);
    logic [14:0] a;
    int          cyc;
    bit          ack_at_ready;
    int          rd_at_ready;
    logic [11:0] got;
    a = {tg, ln, wd};
    @(posedge clk); #1;
    reads_n = 0; writes_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wdat;
    cyc = 0;
    forever begin
      @(negedge clk); #(CLK_PERIOD/4);
      if (cpu_ready) break;
      cyc++;
    end
    got = cpu_rdata; ack_at_ready = mem_ack; rd_at_ready = reads_n;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    exp_acc++;
    if (exp_is_hit) exp_hit++;
    if (!we) begin
      chk(got == exp_rd, "R5", "load data", int'(got), int'(exp_rd));
      if (exp_is_hit) begin
        // R3 / R1: resident line, same cycle, no memory traffic
        chk(cyc == 0, "R3", "hit latency", cyc, 0);
        chk(rd_at_ready == 0, "R3", "hit memory reads", rd_at_ready, 0);
      end else begin
        // R4: eight ascending reads; R9: ready only after all of them
        chk(rd_at_ready == 8, "R9", "reads before ready", rd_at_ready, 8);
        for (int k = 0; k < 8; k++)
          chk(rd_log[k] == int'({tg, ln, 3'(k)}), "R4", "fill address order",
              rd_log[k], int'({tg, ln, 3'(k)}));
      end
    end else begin
      // R9: store finishes exactly with the memory acknowledge
      chk(ack_at_ready, "R9", "store ready with ack", int'(ack_at_ready), 1);
      chk(writes_n == 1, "R7", "memory writes per store", writes_n, 1);
      chk(last_waddr == a && last_wdata == wdat, "R7", "memory write address",
          int'(last_waddr), int'(a));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    chk(cpu_ready == 1'b0, "R2", "ready after reset", int'(cpu_ready), 0);
    chk(mem_req == 1'b0, "R2", "mem_req after reset", int'(mem_req), 0);
    chk(hit_count == 0 && access_count == 0, "R2", "counters after reset",
        int'(access_count), 0);

    // R2, R4, R5: first touch of every line misses and fills
    for (int l = 0; l < 64; l++)
      access(1'b0, 6'd1, 6'(l), 3'(l), 12'h0, 1'b0, mem_val({6'd1, 6'(l), 3'(l)}));

    // R1, R3: every cached word now hits with the memory value
    for (int i = 0; i < 512; i++)
      access(1'b0, 6'd1, 6'(i >> 3), 3'(i), 12'h0, 1'b1, mem_val({6'd1, 9'(i)}));

    // R6: another tag evicts the slot; the old tag misses again
    access(1'b0, 6'd2, 6'd5, 3'd4, 12'h0, 1'b0, mem_val({6'd2, 6'd5, 3'd4}));
    access(1'b0, 6'd2, 6'd5, 3'd7, 12'h0, 1'b1, mem_val({6'd2, 6'd5, 3'd7}));
    access(1'b0, 6'd1, 6'd5, 3'd3, 12'h0, 1'b0, mem_val({6'd1, 6'd5, 3'd3}));
    access(1'b0, 6'd1, 6'd5, 3'd0, 12'h0, 1'b1, mem_val({6'd1, 6'd5, 3'd0}));

    // R7: store hits update cache and memory
    access(1'b1, 6'd1, 6'd5, 3'd2, 12'habc, 1'b1, 12'h0);
    access(1'b0, 6'd1, 6'd5, 3'd2, 12'h0, 1'b1, 12'habc);
    for (int w = 0; w < 8; w++) begin
      access(1'b1, 6'd1, 6'd20, 3'(w), 12'(12'h500 + w * 3), 1'b1, 12'h0);
      access(1'b0, 6'd1, 6'd20, 3'(w), 12'h0, 1'b1, 12'(12'h500 + w * 3));
    end

    // R8: store miss writes memory only
    access(1'b1, 6'd3, 6'd9, 3'd1, 12'h123, 1'b0, 12'h0);
    access(1'b0, 6'd1, 6'd9, 3'd1, 12'h0, 1'b1, mem_val({6'd1, 6'd9, 3'd1}));
    chk(mem_val({6'd1, 6'd9, 3'd1}) != 12'h123, "R8", "slot kept old data", 0, 1);
    access(1'b0, 6'd3, 6'd9, 3'd1, 12'h0, 1'b0, 12'h123);
    // R1: same line/word, different tag, after the slot changed hands
    access(1'b0, 6'd1, 6'd9, 3'd1, 12'h0, 1'b0, mem_val({6'd1, 6'd9, 3'd1}));

    // R10: counters
    #1;
    chk(int'(access_count) == exp_acc, "R10", "access count", int'(access_count), exp_acc);
    chk(int'(hit_count) == exp_hit, "R10", "hit count", int'(hit_count), exp_hit);
    repeat (3) @(posedge clk);
    #1;
    chk(int'(access_count) == exp_acc, "R10", "idle access count", int'(access_count), exp_acc);

    // R11: memory request held stable while waiting
    chk(hold_err == 0, "R11", "request stability", hold_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule